// File: doc/BRIEF.md
# Pin Event Interrupt Controller

This block watches 32 already-synchronized input pins and turns selected pin conditions into one interrupt line. Each pin is set up on its own to fire on a low level, a high level, a rising edge or a falling edge. A separate override bit per pin makes it fire on both edges. When a pin's condition is met, a sticky pending bit for that pin is set. Software clears a pending bit by writing a one to it. A per-pin enable word selects which pending bits may drive the interrupt line.

Software reaches the configuration through a small register bus with address, write data, write strobe, read strobe and registered read data. Every register resets to zero. After reset every pin is therefore in low-level mode and disabled, so a low pin shows as pending but raises no interrupt. All pins are plain control and status signals, so the block has no handshake.

Top module: `pin_event_irq`

## Requirements
- R1: While reset is asserted, `pending_o`, `irq_o` and `rd_data_o` are zero. After reset, every configuration register reads back as zero.
- R2: Pin n takes a 2-bit trigger code: 0 means low level, 1 high level, 2 rising edge, 3 falling edge. For n < 16 the code sits at bits [2n+1:2n] of offset 0x0C. For n >= 16 it sits at bits [2(n-16)+1:2(n-16)] of offset 0x10.
- R3: In a level mode the pending bit is set again on every cycle the level is present, so a clear has no lasting effect while the level holds.
- R4: An edge is found by comparing the sampled pin with its value one cycle earlier. A pending bit, once set, stays set until it is cleared.
- R5: When bit n of offset 0x1C is 1, pin n fires on both its rising and falling edges and its trigger code is ignored.
- R6: Writing to offset 0x18 clears each pending bit whose data bit is 1. Data bits of 0 leave the pending bits unchanged.
- R7: If a pin event and a clear hit the same pending bit in the same cycle, the bit ends up set.
- R8: Offset 0x14 holds the enable word. `irq_o` is a register that goes high one cycle after some pending bit is set while its enable bit is 1.
- R9: Pending bits are set whether or not the pin is enabled. Enabling a pin that is already pending raises `irq_o`.
- R10: A read strobe returns, on the next cycle, the register at the given address. Offset 0x18 returns the pending bits. Any other address returns zero.
- R11: `pending_o` always equals the pending register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pins_i | input | 32 | Synchronized pin levels |
| addr_i | input | 8 | Register byte address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Read data, valid the cycle after the strobe |
| irq_o | output | 1 | Combined interrupt |
| pending_o | output | 32 | Per-pin pending bits |

## Verification
The assertions check several rules on every cycle:
- a both-edges pin fires exactly when its level changes;
- a pending bit that is not cleared stays set;
- a clear with no competing event leaves the bit at zero;
- an event always sets its bit;
- an all-zero enable word keeps the interrupt low;
- an enable write lands.

Some behaviour can only be shown by the bench's scenarios, because it depends on the full configuration and on a sequence of cycles:
- each trigger code's decode at its field position;
- a level re-asserting right after a clear;
- an unmasked pending pin raising the interrupt;
- read-back of each register.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  localparam int OFS_TRIG_LO = 'h0C;
  localparam int OFS_TRIG_HI = 'h10;
  localparam int OFS_ENABLE  = 'h14;
  localparam int OFS_PEND    = 'h18;
  localparam int OFS_BOTH    = 'h1C;
endpackage

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                rd_en_i,
  input  logic [DATA_W-1:0]   pend_i,
  output logic [2*DATA_W-1:0] trig_o,
  output logic [DATA_W-1:0]   enable_o,
  output logic [DATA_W-1:0]   both_o,
  output logic [DATA_W-1:0]   clr_o,
  output logic [DATA_W-1:0]   rd_data_o
);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(OFS_TRIG_LO);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(OFS_TRIG_HI);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);
  localparam logic [ADDR_W-1:0] A_BOTH = ADDR_W'(OFS_BOTH);

  logic [DATA_W-1:0] trig_lo_q, trig_hi_q, enable_q, both_q, rd_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      trig_lo_q <= '0;
      trig_hi_q <= '0;
      enable_q  <= '0;
      both_q    <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_LO)   trig_lo_q <= wr_data_i;
      if (addr_i == A_HI)   trig_hi_q <= wr_data_i;
      if (addr_i == A_EN)   enable_q  <= wr_data_i;
      if (addr_i == A_BOTH) both_q    <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rd_q <= '0;
    end else if (rd_en_i) begin
      if      (addr_i == A_LO)   rd_q <= trig_lo_q;
      else if (addr_i == A_HI)   rd_q <= trig_hi_q;
      else if (addr_i == A_EN)   rd_q <= enable_q;
      else if (addr_i == A_PEND) rd_q <= pend_i;
      else if (addr_i == A_BOTH) rd_q <= both_q;
      else                       rd_q <= '0;
    end
  end

  assign clr_o     = (wr_en_i && addr_i == A_PEND) ? wr_data_i : '0;
  assign trig_o    = {trig_hi_q, trig_lo_q};
  assign enable_o  = enable_q;
  assign both_o    = both_q;
  assign rd_data_o = rd_q;

  // R8: an enable write is visible on the next cycle
  p_enable_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_EN) |=> (enable_o == $past(wr_data_i)));
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import pin_irq_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_PINS-1:0]   pins_i,
  input  logic [2*N_PINS-1:0] trig_i,
  input  logic [N_PINS-1:0]   both_i,
  output logic [N_PINS-1:0]   evt_o
);
  logic [N_PINS-1:0] prev_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pins_i;
  end

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    trig_e mode;
    logic  hit;
    assign mode = trig_e'(trig_i[2*g +: 2]);
    always_comb begin
      unique case (mode)
        TRIG_LOW:  hit = ~pins_i[g];
        TRIG_HIGH: hit = pins_i[g];
        TRIG_RISE: hit = pins_i[g] & ~prev_q[g];
        TRIG_FALL: hit = ~pins_i[g] & prev_q[g];
        default:   hit = 1'b0;
      endcase
    end
    assign evt_o[g] = both_i[g] ? (pins_i[g] ^ prev_q[g]) : hit;
  end

  // R5: a both-edges pin fires on any change and never while steady
  p_both_change_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((both_i & (pins_i ^ prev_q) & ~evt_o) == '0));
  p_both_steady_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((both_i & ~(pins_i ^ prev_q) & evt_o) == '0));
endmodule

// File: rtl/pin_irq_status.sv
module pin_irq_status #(
  parameter int N_PINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] evt_i,
  input  logic [N_PINS-1:0] clr_i,
  input  logic [N_PINS-1:0] enable_i,
  output logic [N_PINS-1:0] pend_o,
  output logic              irq_o
);
  logic [N_PINS-1:0] pend_q;
  logic              irq_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~clr_i) | evt_i;
      irq_q  <= |(pend_q & enable_i);
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = irq_q;

  // R4: a pending bit not being cleared stays set
  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & ~clr_i) != '0) |=> ((pend_q & $past(pend_q & ~clr_i)) == $past(pend_q & ~clr_i)));
  // R6: a clear with no competing event leaves the bit at zero
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~evt_i) != '0) |=> ((pend_q & $past(clr_i & ~evt_i)) == '0));
  // R7: an event sets its bit even against a clear
  p_event_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));
  // R8: no enabled pin, no interrupt
  p_masked_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i == '0) |=> !irq_o);
endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] pins_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] pending_o
);
  localparam int N_PINS = DATA_W;

  logic [2*N_PINS-1:0] trig;
  logic [N_PINS-1:0]   enable, both, clr, evt, pend;

  pin_irq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_en_i, .wr_data_i, .rd_en_i,
    .pend_i(pend), .trig_o(trig), .enable_o(enable), .both_o(both),
    .clr_o(clr), .rd_data_o
  );

  pin_irq_detect #(.N_PINS(N_PINS)) u_detect (
    .clk_i, .rst_ni, .pins_i, .trig_i(trig), .both_i(both), .evt_o(evt)
  );

  pin_irq_status #(.N_PINS(N_PINS)) u_status (
    .clk_i, .rst_ni, .evt_i(evt), .clr_i(clr), .enable_i(enable),
    .pend_o(pend), .irq_o
  );

  assign pending_o = pend;

  // R11: pending output mirrors the pending register
  p_pending_out_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_o == u_status.pend_o));
endmodule

// File: tb/pin_event_irq_test.sv
module pin_event_irq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] pins = '0, wdata = '0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] rd_data, pending;
  logic        irq;

  pin_event_irq uut (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .addr_i(addr),
    .wr_en_i(wr_en), .wr_data_i(wdata), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .irq_o(irq), .pending_o(pending)
  );

  int    n_tests = 0, n_fail = 0;
  string tag = "R1";

  logic [31:0] m_lo, m_hi, m_en, m_both, m_pend, m_prev, m_rd;
  logic        m_irq, m_rdv;

  function automatic logic [31:0] f_evt(input logic [31:0] p, q, lo, hi, bo);
    logic [31:0] e;
    for (int i = 0; i < 32; i++) begin
      logic [1:0] c;
      c = (i < 16) ? lo[2*i +: 2] : hi[2*(i-16) +: 2];
      if (bo[i]) e[i] = p[i] ^ q[i];
      else case (c)
        2'd0: e[i] = ~p[i];
        2'd1: e[i] = p[i];
        2'd2: e[i] = p[i] & ~q[i];
        default: e[i] = ~p[i] & q[i];
      endcase
    end
    return e;
  endfunction

  function automatic logic [31:0] f_reg(input logic [7:0] a);
    case (a)
      8'h0C: return m_lo;
      8'h10: return m_hi;
      8'h14: return m_en;
      8'h18: return m_pend;
      8'h1C: return m_both;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lo <= '0; m_hi <= '0; m_en <= '0; m_both <= '0;
      m_pend <= '0; m_prev <= '0; m_rd <= '0; m_irq <= 1'b0; m_rdv <= 1'b0;
    end else begin
      m_pend <= (m_pend & ~((wr_en && addr == 8'h18) ? wdata : 32'h0))
                | f_evt(pins, m_prev, m_lo, m_hi, m_both);
      m_prev <= pins;
      m_irq  <= |(m_pend & m_en);
      m_rdv  <= rd_en;
      if (rd_en) m_rd <= f_reg(addr);
      if (wr_en) case (addr)
        8'h0C: m_lo <= wdata;
        8'h10: m_hi <= wdata;
        8'h14: m_en <= wdata;
        8'h1C: m_both <= wdata;
        default: ;
      endcase
    end
  end

  task automatic chk(input string t, input logic [31:0] act, exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  // R11 / R8 / R10: lockstep comparison on every falling edge
  always @(negedge clk) begin
    chk({tag, " pending (R11)"}, pending, m_pend);
    chk({tag, " irq (R8)"}, {31'b0, irq}, {31'b0, m_irq});
    if (m_rdv) chk({tag, " read data (R10)"}, rd_data, m_rd);
  end

  task automatic cyc();
    @(posedge clk); #2;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(); wr_en = 1'b1; addr = a; wdata = d;
  endtask
  task automatic rd(input logic [7:0] a);
    cyc(); rd_en = 1'b1; addr = a;
  endtask
  task automatic look(input string t, input logic [31:0] act, exp);
    @(negedge clk); #1; chk(t, act, exp);
  endtask

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    tag = "R1";
    look("R1 reset pending", pending, 32'h0);
    look("R1 reset irq", {31'b0, irq}, 32'h0);
    cyc(); rst_n = 1'b1;
    tag = "R10";
    rd(8'h0C); rd(8'h10); rd(8'h14); rd(8'h1C); rd(8'h00); rd(8'h20); rd(8'h18);
    cyc();
    tag = "R3";
    wr(8'h18, 32'hFFFF_FFFF); cyc();
    look("R3 low level reasserts after clear", pending, 32'hFFFF_FFFF);
    tag = "R2";
    wr(8'h0C, 32'h5555_5595); wr(8'h10, 32'h5555_557D);
    wr(8'h18, 32'hFFFF_FFFF); wr(8'h18, 32'hFFFF_FFFF); cyc();
    look("R2 high/edge codes quiet with pins low", pending, 32'h0);
    cyc(); pins[16] = 1'b1; cyc();
    look("R2 pin16 high level", pending[16], 1'b1);
    cyc(); pins[17] = 1'b1; cyc(); pins[17] = 1'b0; cyc();
    look("R2 pin17 falling edge", pending[17], 1'b1);
    tag = "R4";
    wr(8'h18, 32'hFFFF_FFFF); cyc(); pins[16] = 1'b0; pins[3] = 1'b1;
    cyc(); cyc(); cyc();
    look("R4 rising edge latched and held", pending[3], 1'b1);
    wr(8'h18, 32'h0000_0008); cyc();
    look("R4 cleared with pin steady high", pending[3], 1'b0);
    tag = "R6";
    cyc(); pins[3] = 1'b0; cyc(); pins[3] = 1'b1; cyc();
    wr(8'h18, 32'h0); cyc();
    look("R6 zero write keeps bit", pending[3], 1'b1);
    tag = "R7";
    wr(8'h18, 32'h8); cyc(); pins[3] = 1'b0; cyc();
    wr(8'h18, 32'h8); pins[3] = 1'b1; cyc();
    look("R7 event beats clear", pending[3], 1'b1);
    tag = "R9";
    cyc(); cyc();
    look("R9 masked pending gives no irq", {31'b0, irq}, 32'h0);
    tag = "R8";
    wr(8'h14, 32'h8); cyc(); cyc();
    look("R8 irq after unmask", {31'b0, irq}, 32'h1);
    wr(8'h18, 32'h8); cyc(); cyc();
    look("R8 irq drops after clear", {31'b0, irq}, 32'h0);
    tag = "R5";
    wr(8'h1C, 32'h20); wr(8'h18, 32'hFFFF_FFFF); cyc();
    pins[5] = 1'b1; cyc();
    look("R5 rising edge on both-edge pin", pending[5], 1'b1);
    wr(8'h18, 32'h20); cyc(); cyc();
    look("R5 high level ignored", pending[5], 1'b0);
    pins[5] = 1'b0; cyc();
    look("R5 falling edge on both-edge pin", pending[5], 1'b1);
    tag = "R11";
    for (int k = 0; k < 3000; k++) begin
      int op;
      cyc();
      pins = pins ^ ($urandom & $urandom & $urandom);
      op = $urandom_range(0, 9);
      if (op == 0) begin
        wr_en = 1'b1; wdata = $urandom;
        case ($urandom_range(0, 4))
          0: addr = 8'h0C; 1: addr = 8'h10; 2: addr = 8'h14;
          3: addr = 8'h18; default: addr = 8'h1C;
        endcase
      end else if (op < 3) begin
        wr_en = 1'b1; addr = 8'h18; wdata = $urandom;
      end else if (op == 3) begin
        rd_en = 1'b1; addr = 8'(4 * $urandom_range(0, 9));
      end
    end
    cyc(); cyc();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule